// File: doc/BRIEF.md
# UART Internal Loopback and Modem-Status Path

This block sits between the register file of a UART and its receive FIFO. It decodes the loopback enable and the four modem-control outputs from control-register writes, it tracks the line-break bit of the line-control register, and it owns the single push port into the RX FIFO. In normal operation the modem-status flags are sampled from the external modem pins, and received bytes and break events from the external receiver go into the FIFO.

When loopback is enabled, the external receiver and the modem pins are cut off. The modem-control outputs drive the status flags through a fixed cross-mapping, and each modem interrupt level follows its flag. Every byte written for transmission is also fed straight into the RX FIFO. Raising the break bit queues a break entry. There is no bit-level serial timing on this path: a looped byte appears on the push port one cycle after its write strobe.

The push port never presents an entry while the FIFO reports full. A request that meets a full FIFO is dropped and raises a one-cycle overrun strobe.

Top module: `uart_loopback_path`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the outputs `fr_modem`, the four `lvl_*` levels, `modem_int`, `push_valid` and `overrun` are 0, and loopback is off.
- R2: With loopback off, the `fr_modem` flags copy the modem pins one cycle later, at these positions: RI at bit 8, DCD at bit 2, DSR at bit 1, CTS at bit 0. All other bits of `fr_modem` are 0.
- R3: A control write sets loopback with bit 7 of `ctrl_wdata`. While loopback is on, RI follows control bit 13, DCD follows bit 12, CTS follows bit 11 and DSR follows bit 10. The pins are ignored.
- R4: The flag mapping becomes visible in the cycle after the control write that enables loopback, even if no other control bit changes.
- R5: `lvl_ri`, `lvl_dcd`, `lvl_dsr` and `lvl_cts` always equal their flag bits in `fr_modem`. `modem_int` is the OR of the four levels.
- R6: With loopback on, a `tx_strobe` pushes the entry {bit 10 = 0, bits 7:0 = `tx_byte`} in the next cycle.
- R7: With loopback on, a line-control write that changes the break bit from 0 to 1 pushes an entry with bit 10 set and bits 7:0 zero. Rewriting the bit while it is already 1 pushes nothing.
- R8: With loopback on, external bytes (`rx_valid`) and external breaks (`rx_break`) never reach the push port.
- R9: With loopback off, an external byte pushes {0, `rx_byte`} and an external break pushes an entry with bit 10 set and zero data. The break wins if both arrive together. `tx_strobe` pushes nothing.
- R10: If `fifo_full` is high in the cycle of a push request, no push occurs and `overrun` is 1 for exactly the next cycle.
- R11: In loopback, a break request and a `tx_strobe` in the same cycle push the break entry. The byte is dropped and `overrun` pulses.
- R12: The push path uses the loopback state from before a control write. A `tx_strobe` in the same cycle as the write that enables loopback is not looped back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control-register write strobe |
| ctrl_wdata | input | 16 | Control-register write data |
| lcr_wr | input | 1 | Line-control write strobe |
| lcr_brk | input | 1 | Break bit of the line-control write data |
| tx_strobe | input | 1 | Transmit data write strobe |
| tx_byte | input | 8 | Transmit byte |
| rx_valid | input | 1 | External received byte valid |
| rx_byte | input | 8 | External received byte |
| rx_break | input | 1 | External break detected |
| pin_ri | input | 1 | External ring-indicator pin |
| pin_dcd | input | 1 | External carrier-detect pin |
| pin_dsr | input | 1 | External data-set-ready pin |
| pin_cts | input | 1 | External clear-to-send pin |
| fifo_full | input | 1 | RX FIFO full |
| fr_modem | output | 9 | Modem-status bits at their flag-register positions |
| lvl_ri | output | 1 | RI interrupt level |
| lvl_dcd | output | 1 | DCD interrupt level |
| lvl_dsr | output | 1 | DSR interrupt level |
| lvl_cts | output | 1 | CTS interrupt level |
| modem_int | output | 1 | OR of the modem interrupt levels |
| push_valid | output | 1 | RX FIFO push strobe |
| push_data | output | 11 | RX FIFO entry: bit 10 break, bits 7:0 data |
| overrun | output | 1 | One-cycle strobe for a push dropped on a full FIFO |

## Verification
On every cycle, the assertions check these properties:
- each interrupt level matches its flag bit;
- the looped flags match the registered control outputs;
- no push follows a cycle in which the FIFO was full;
- a break entry carries zero data;
- in loopback, a push is always caused by a transmit or break request, never by the external receiver.

Only the bench's scenarios can show the rest, through its per-cycle reference model and directed cases:
- the timing of the enable write when only bit 7 is set;
- the 0-to-1 edge rule for breaks;
- the collision of a break and a byte;
- the handover from pins to loopback and back.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;
  localparam int CTRL_W   = 16;
  localparam int LBE_BIT  = 7;
  localparam int OUT2_BIT = 13;
  localparam int OUT1_BIT = 12;
  localparam int RTS_BIT  = 11;
  localparam int DTR_BIT  = 10;
  localparam int FLAG_W   = 9;
  localparam int RI_POS   = 8;
  localparam int DCD_POS  = 2;
  localparam int DSR_POS  = 1;
  localparam int CTS_POS  = 0;
  localparam int DATA_W   = 8;
  localparam int BRK_POS  = 10;
  localparam int ENTRY_W  = BRK_POS + 1;

  typedef struct packed {
    logic lb_en;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } lb_ctrl_t;

  typedef struct packed {
    logic ri;
    logic dcd;
    logic dsr;
    logic cts;
  } mstat_t;

  function automatic lb_ctrl_t decode_ctrl(input logic [CTRL_W-1:0] w);
    lb_ctrl_t c;
    c.lb_en = w[LBE_BIT];
    c.out2  = w[OUT2_BIT];
    c.out1  = w[OUT1_BIT];
    c.rts   = w[RTS_BIT];
    c.dtr   = w[DTR_BIT];
    return c;
  endfunction

  // Cross-mapping of modem-control outputs onto status inputs
  function automatic mstat_t loop_map(input lb_ctrl_t c);
    mstat_t s;
    s.ri  = c.out2;
    s.dcd = c.out1;
    s.cts = c.rts;
    s.dsr = c.dtr;
    return s;
  endfunction

  function automatic logic [FLAG_W-1:0] place_flags(input mstat_t s);
    logic [FLAG_W-1:0] f;
    f = '0;
    f[RI_POS]  = s.ri;
    f[DCD_POS] = s.dcd;
    f[DSR_POS] = s.dsr;
    f[CTS_POS] = s.cts;
    return f;
  endfunction

  function automatic logic [ENTRY_W-1:0] make_entry(input logic brk,
                                                    input logic [DATA_W-1:0] b);
    logic [ENTRY_W-1:0] e;
    e = '0;
    e[BRK_POS] = brk;
    e[DATA_W-1:0] = brk ? '0 : b;
    return e;
  endfunction
endpackage

// File: rtl/lb_ctrl_reg.sv
module lb_ctrl_reg
  import uart_lb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              lcr_wr,
  input  logic              lcr_brk,
  output lb_ctrl_t          ctrl_q,
  output lb_ctrl_t          ctrl_nxt,
  output logic              brk_rise
);
  logic brk_q;

  always_comb begin
    ctrl_nxt = ctrl_wr ? decode_ctrl(ctrl_wdata) : ctrl_q;
  end

  assign brk_rise = lcr_wr && lcr_brk && !brk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      brk_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_nxt;
      if (lcr_wr) brk_q <= lcr_brk;
    end
  end

  AST_BRK_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_rise |=> brk_q); // R7
endmodule

// File: rtl/lb_modem_status.sv
module lb_modem_status
  import uart_lb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  lb_ctrl_t          ctrl_nxt,
  input  mstat_t            pins,
  output logic [FLAG_W-1:0] flags_q,
  output mstat_t            lvl_q,
  output logic              any_lvl
);
  mstat_t src;

  always_comb begin
    src = ctrl_nxt.lb_en ? loop_map(ctrl_nxt) : pins;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      lvl_q   <= '0;
    end else begin
      flags_q <= place_flags(src);
      lvl_q   <= src;
    end
  end

  assign any_lvl = |lvl_q;

  AST_LVL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q.ri == flags_q[RI_POS]) && (lvl_q.dcd == flags_q[DCD_POS]) &&
    (lvl_q.dsr == flags_q[DSR_POS]) && (lvl_q.cts == flags_q[CTS_POS])); // R5
endmodule

// File: rtl/lb_rx_arbiter.sv
module lb_rx_arbiter
  import uart_lb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lb_en,
  input  logic               tx_strobe,
  input  logic [DATA_W-1:0]  tx_byte,
  input  logic               brk_rise,
  input  logic               rx_valid,
  input  logic [DATA_W-1:0]  rx_byte,
  input  logic               rx_break,
  input  logic               fifo_full,
  output logic               push_valid,
  output logic [ENTRY_W-1:0] push_data,
  output logic               overrun
);
  logic               lb_req;
  logic               ext_req;
  logic               collide;
  logic               req;
  logic [ENTRY_W-1:0] entry;
  logic               lb_brk;

  assign lb_brk  = lb_en && brk_rise;
  assign lb_req  = lb_en && (brk_rise || tx_strobe);
  assign ext_req = !lb_en && (rx_valid || rx_break);
  assign collide = lb_en && brk_rise && tx_strobe;
  assign req     = lb_req || ext_req;

  always_comb begin
    if (lb_en) entry = make_entry(lb_brk, tx_byte);
    else       entry = make_entry(rx_break, rx_byte);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_valid <= 1'b0;
      push_data  <= '0;
      overrun    <= 1'b0;
    end else begin
      push_valid <= req && !fifo_full;
      if (req && !fifo_full) push_data <= entry;
      overrun    <= (req && fifo_full) || collide;
    end
  end

  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> $past(!fifo_full)); // R10
  AST_BRK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_data[BRK_POS]) |-> (push_data[DATA_W-1:0] == '0)); // R7
  AST_LB_NO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && $past(lb_en)) |-> $past(tx_strobe || brk_rise)); // R8
endmodule

// File: rtl/uart_loopback_path.sv
module uart_loopback_path
  import uart_lb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_wr,
  input  logic [CTRL_W-1:0]  ctrl_wdata,
  input  logic               lcr_wr,
  input  logic               lcr_brk,
  input  logic               tx_strobe,
  input  logic [DATA_W-1:0]  tx_byte,
  input  logic               rx_valid,
  input  logic [DATA_W-1:0]  rx_byte,
  input  logic               rx_break,
  input  logic               pin_ri,
  input  logic               pin_dcd,
  input  logic               pin_dsr,
  input  logic               pin_cts,
  input  logic               fifo_full,
  output logic [FLAG_W-1:0]  fr_modem,
  output logic               lvl_ri,
  output logic               lvl_dcd,
  output logic               lvl_dsr,
  output logic               lvl_cts,
  output logic               modem_int,
  output logic               push_valid,
  output logic [ENTRY_W-1:0] push_data,
  output logic               overrun
);
  lb_ctrl_t ctrl_q;
  lb_ctrl_t ctrl_nxt;
  logic     brk_rise;
  mstat_t   pins;
  mstat_t   lvl;

  assign pins = '{ri: pin_ri, dcd: pin_dcd, dsr: pin_dsr, cts: pin_cts};

  lb_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .lcr_wr(lcr_wr), .lcr_brk(lcr_brk), .ctrl_q(ctrl_q), .ctrl_nxt(ctrl_nxt),
    .brk_rise(brk_rise)
  );

  lb_modem_status u_mstat (
    .clk(clk), .rst_n(rst_n), .ctrl_nxt(ctrl_nxt), .pins(pins),
    .flags_q(fr_modem), .lvl_q(lvl), .any_lvl(modem_int)
  );

  lb_rx_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .lb_en(ctrl_q.lb_en), .tx_strobe(tx_strobe),
    .tx_byte(tx_byte), .brk_rise(brk_rise), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_break(rx_break), .fifo_full(fifo_full),
    .push_valid(push_valid), .push_data(push_data), .overrun(overrun)
  );

  assign lvl_ri  = lvl.ri;
  assign lvl_dcd = lvl.dcd;
  assign lvl_dsr = lvl.dsr;
  assign lvl_cts = lvl.cts;

  AST_LOOP_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.lb_en |-> (fr_modem[RI_POS] == ctrl_q.out2 && fr_modem[DCD_POS] == ctrl_q.out1 &&
                      fr_modem[CTS_POS] == ctrl_q.rts && fr_modem[DSR_POS] == ctrl_q.dtr)); // R3
  AST_FLAG_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_modem & ~place_flags('1)) == '0); // R2
endmodule

// File: tb/uart_loopback_path_test.sv
module uart_loopback_path_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic        lcr_wr = 1'b0, lcr_brk = 1'b0;
  logic        tx_strobe = 1'b0;
  logic [7:0]  tx_byte = '0;
  logic        rx_valid = 1'b0, rx_break = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        pin_ri = 0, pin_dcd = 0, pin_dsr = 0, pin_cts = 0;
  logic        fifo_full = 1'b0;
  logic [8:0]  fr_modem;
  logic        lvl_ri, lvl_dcd, lvl_dsr, lvl_cts, modem_int;
  logic        push_valid, overrun;
  logic [10:0] push_data;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_loopback_path uut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .lcr_wr(lcr_wr), .lcr_brk(lcr_brk), .tx_strobe(tx_strobe), .tx_byte(tx_byte),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_break(rx_break),
    .pin_ri(pin_ri), .pin_dcd(pin_dcd), .pin_dsr(pin_dsr), .pin_cts(pin_cts),
    .fifo_full(fifo_full), .fr_modem(fr_modem), .lvl_ri(lvl_ri), .lvl_dcd(lvl_dcd),
    .lvl_dsr(lvl_dsr), .lvl_cts(lvl_cts), .modem_int(modem_int),
    .push_valid(push_valid), .push_data(push_data), .overrun(overrun)
  );

  // Behavioural reference model
  int m_lb, m_ri, m_dcd, m_dsr, m_cts, m_brk;
  int m_o2, m_o1, m_rts, m_dtr;
  int m_push, m_data, m_ovr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lb = 0; m_o2 = 0; m_o1 = 0; m_rts = 0; m_dtr = 0; m_brk = 0;
      m_ri = 0; m_dcd = 0; m_dsr = 0; m_cts = 0;
      m_push = 0; m_data = 0; m_ovr = 0;
    end else begin
      int req, d, ov;
      req = 0; d = 0; ov = 0;
      if (m_lb != 0) begin
        if (lcr_wr && lcr_brk && m_brk == 0) begin
          req = 1; d = 1024;
          if (tx_strobe) ov = 1;
        end else if (tx_strobe) begin
          req = 1; d = tx_byte;
        end
      end else if (rx_break) begin
        req = 1; d = 1024;
      end else if (rx_valid) begin
        req = 1; d = rx_byte;
      end
      if (req != 0 && fifo_full) begin req = 0; ov = 1; end
      m_push = req;
      if (req != 0) m_data = d;
      m_ovr = ov;
      if (lcr_wr) m_brk = lcr_brk;
      if (ctrl_wr) begin
        m_lb = ctrl_wdata[7]; m_o2 = ctrl_wdata[13]; m_o1 = ctrl_wdata[12];
        m_rts = ctrl_wdata[11]; m_dtr = ctrl_wdata[10];
      end
      if (m_lb != 0) begin
        m_ri = m_o2; m_dcd = m_o1; m_cts = m_rts; m_dsr = m_dtr;
      end else begin
        m_ri = pin_ri; m_dcd = pin_dcd; m_cts = pin_cts; m_dsr = pin_dsr;
      end
    end
  end

  function automatic int model_flags();
    return m_ri * 256 + m_dcd * 4 + m_dsr * 2 + m_cts;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Per-cycle comparison with the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      chk("R3 flags vs model", int'(fr_modem), model_flags());
      chk("R5 levels vs model", {lvl_ri, lvl_dcd, lvl_dsr, lvl_cts}, m_ri*8 + m_dcd*4 + m_dsr*2 + m_cts);
      chk("R5 modem_int", int'(modem_int), (m_ri | m_dcd | m_dsr | m_cts));
      chk("R6 push_valid vs model", int'(push_valid), m_push);
      if (push_valid && m_push != 0) chk("R6 push_data vs model", int'(push_data), m_data);
      chk("R10 overrun vs model", int'(overrun), m_ovr);
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    done = 1;
    summary();
  end

  task automatic step(); @(negedge clk); endtask

  task automatic clear_in();
    ctrl_wr = 0; lcr_wr = 0; tx_strobe = 0; rx_valid = 0; rx_break = 0; fifo_full = 0;
  endtask

  task automatic wr_ctrl(input logic [15:0] v);
    ctrl_wr = 1; ctrl_wdata = v; step(); ctrl_wr = 0;
  endtask

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    step(); step();
    // R1 reset state
    chk("R1 fr_modem in reset", int'(fr_modem), 0);
    chk("R1 push/overrun in reset", {push_valid, overrun, modem_int}, 0);
    pin_ri = 1; pin_cts = 1;
    rst_n = 1;
    chk("R1 after release", int'(fr_modem), 0);
    step();
    chk("R2 pins RI+CTS", int'(fr_modem), 9'h101);
    pin_ri = 0; pin_dsr = 1; pin_dcd = 1; step();
    chk("R2 pins DCD+DSR+CTS", int'(fr_modem), 9'h007);
    // R9 normal receive
    rx_valid = 1; rx_byte = 8'h5A; step(); rx_valid = 0;
    chk("R9 ext byte push", {push_valid, push_data}, {1'b1, 11'h05A});
    rx_break = 1; rx_valid = 1; step(); rx_break = 0; rx_valid = 0;
    chk("R9 ext break push", {push_valid, push_data}, {1'b1, 11'h400});
    tx_strobe = 1; tx_byte = 8'h33; step(); tx_strobe = 0;
    chk("R9 tx not looped when off", int'(push_valid), 0);
    // R10 full
    fifo_full = 1; rx_valid = 1; rx_byte = 8'h11; step(); clear_in();
    chk("R10 full drops push", {push_valid, overrun}, 2'b01);
    step();
    chk("R10 overrun one cycle", int'(overrun), 0);
    // R4 + R12: enable with only bit 7, tx in same cycle
    tx_strobe = 1; tx_byte = 8'h77; wr_ctrl(16'h0080); tx_strobe = 0;
    chk("R4 enable alone clears flags", int'(fr_modem), 0);
    chk("R12 tx in enabling cycle not looped", int'(push_valid), 0);
    wr_ctrl(16'h2080); chk("R3 OUT2->RI", int'(fr_modem), 9'h100);
    chk("R5 lvl_ri and int", {lvl_ri, modem_int}, 2'b11);
    wr_ctrl(16'h1080); chk("R3 OUT1->DCD", int'(fr_modem), 9'h004);
    wr_ctrl(16'h0880); chk("R3 RTS->CTS", int'(fr_modem), 9'h001);
    wr_ctrl(16'h0480); chk("R3 DTR->DSR", int'(fr_modem), 9'h002);
    chk("R5 lvl_dsr only", {lvl_ri, lvl_dcd, lvl_dsr, lvl_cts}, 4'b0010);
    // R6 loop tx
    tx_strobe = 1; tx_byte = 8'hA5; step(); tx_strobe = 0;
    chk("R6 looped byte", {push_valid, push_data}, {1'b1, 11'h0A5});
    // R8 external ignored
    rx_valid = 1; rx_byte = 8'h99; step(); rx_valid = 0;
    chk("R8 ext byte ignored", int'(push_valid), 0);
    rx_break = 1; step(); rx_break = 0;
    chk("R8 ext break ignored", int'(push_valid), 0);
    // R7 break
    lcr_wr = 1; lcr_brk = 1; step(); lcr_wr = 0;
    chk("R7 break entry", {push_valid, push_data}, {1'b1, 11'h400});
    lcr_wr = 1; lcr_brk = 1; step(); lcr_wr = 0;
    chk("R7 no repeat while set", int'(push_valid), 0);
    lcr_wr = 1; lcr_brk = 0; step(); lcr_wr = 0;
    // R11 collision
    lcr_wr = 1; lcr_brk = 1; tx_strobe = 1; tx_byte = 8'h42; step(); clear_in();
    chk("R11 break wins with overrun", {push_valid, push_data, overrun}, {1'b1, 11'h400, 1'b1});
    // R10 in loopback
    fifo_full = 1; tx_strobe = 1; step(); clear_in();
    chk("R10 loop full drop", {push_valid, overrun}, 2'b01);
    // back to normal
    pin_ri = 1; pin_dcd = 0; pin_dsr = 0; pin_cts = 0;
    wr_ctrl(16'h3C00);
    chk("R2 pins after disable", int'(fr_modem), 9'h100);
    // pseudo-random phase against the model
    for (int i = 0; i < 2000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ctrl_wr = (lfsr[3:0] == 4'h0);
      ctrl_wdata = {lfsr[9:6], 2'b00, 2'b00, lfsr[1], 7'h00};
      lcr_wr = lfsr[4] & lfsr[5]; lcr_brk = lfsr[11];
      tx_strobe = lfsr[6]; tx_byte = lfsr[15:8];
      rx_valid = lfsr[7]; rx_break = lfsr[12] & lfsr[13] & lfsr[14];
      rx_byte = lfsr[10:3];
      pin_ri = lfsr[2]; pin_dcd = lfsr[8]; pin_dsr = lfsr[13]; pin_cts = lfsr[0];
      fifo_full = lfsr[14] & lfsr[9];
      step();
    end
    clear_in();
    step();
    done = 1;
    summary();
  end
endmodule